// File: doc/BRIEF.md
# Dual-Width Real-Time Counter with Compare Channels

This block is the counting core of a real-time counter. It advances by one on every cycle where the prescaled tick-enable input is high. At run time it can be switched between a 16-bit and a 32-bit counting width. Each width has its own wrap rule and its own number of active compare channels. Clock selection, prescaling and any crossing between clock domains sit outside the block.

In 16-bit mode, a programmable period value sets the top of the count, and six compare channels are active. In 32-bit mode the count runs through the full 32-bit range, and four compare channels are active. A clear-on-match option can also be set, so that compare channel 0 limits the count. Every wrap and every compare match sets a sticky flag, which software clears by writing a one to the flag's bit. Each condition can also emit a one-cycle event pulse when its bit in an event mask is set. All configuration goes through one simple register write port.

Top module: `rtc_compare_core`

## Requirements
- R1: After reset the visible count is 0, all flags and event pulses are 0 and the event mask is 0. The block is in 32-bit mode with clear-on-match off, all compare values are 0 and the period is 0xFFFF.
- R2: The count advances by exactly one on a cycle with `tick_en` high. It holds its value on a cycle with `tick_en` low and no count write.
- R3: In 32-bit mode, a tick at count 0xFFFFFFFF gives count 0 and sets flag bit 0 (overflow).
- R4: In 16-bit mode, a tick at a count whose low 16 bits equal the period, or equal 0xFFFF, gives count 0 and sets flag bit 0. While in 16-bit mode, bits 31:16 of `count_o` read 0.
- R5: In 32-bit mode with clear-on-match on, a tick at a count equal to compare 0 gives count 0. This wrap does not set the overflow flag, unless the count was 0xFFFFFFFF.
- R6: On a tick, compare channel i sets flag bit i+1 when the new count equals its compare value. In 16-bit mode only the low 16 bits are compared. Channels 0 to 5 are active in 16-bit mode and channels 0 to 3 in 32-bit mode; channels 4 and 5 set nothing in 32-bit mode.
- R7: A write to address 4 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R8: The event mask at address 3 uses the flag bit layout. In the cycle after a flag's condition occurs, `evt_o` shows that bit for one cycle, but only if the bit is enabled in the mask.
- R9: A write to the count at address 1 takes priority over a tick in the same cycle and sets no flag.
- R10: The control register is at address 0: bit 0 selects the mode (0 = 16-bit, 1 = 32-bit) and bit 1 enables clear-on-match. The period is at address 2 (low 16 bits). Compare i is at address 8+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| count_o | output | 32 | Current count (upper half zero in 16-bit mode) |
| flags_o | output | 7 | Sticky flags: bit 0 overflow, bits 1..6 compare 0..5 |
| evt_o | output | 7 | One-cycle event pulses, same bit layout as the flags |

## Verification
A wrong next-count value shows on `count_o` in the cycle after the tick that produced it, so wrap and clear-on-match errors are caught within one tick of the boundary. A wrong mode or channel-active decision shows up as a missing or extra flag bit or event pulse in that same cycle. Because the flags are sticky, an error that no check samples directly still stays visible until software clears it. A write priority mistake shows as a count other than the written value, or as a flag set by a write.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
    localparam int CNT_W        = 32;
    localparam int HALF_W       = 16;
    localparam int NUM_CMP      = 6;
    localparam int NUM_CMP_WIDE = 4;
    localparam int FLAG_W       = NUM_CMP + 1;
    localparam int ADDR_W       = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD = 4'd2;
    localparam logic [ADDR_W-1:0] A_EVCTL  = 4'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

    typedef enum logic {
        MODE_16 = 1'b0,
        MODE_32 = 1'b1
    } cnt_mode_e;

    typedef struct packed {
        logic      clr_on_match;
        cnt_mode_e mode;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] widen16(input logic [HALF_W-1:0] v);
        return {{(CNT_W-HALF_W){1'b0}}, v};
    endfunction

    function automatic int active_channels(input cnt_mode_e m);
        return (m == MODE_32) ? NUM_CMP_WIDE : NUM_CMP;
    endfunction
endpackage

// File: rtl/rtcc_regfile.sv
module rtcc_regfile
    import rtcc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    output ctrl_t                 ctrl_o,
    output logic [HALF_W-1:0]     period_o,
    output logic [FLAG_W-1:0]     evmask_o,
    output logic [CNT_W-1:0]      cmp_o [NUM_CMP]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o   <= '{clr_on_match: 1'b0, mode: MODE_32};
            period_o <= '1;
            evmask_o <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                ctrl_o.mode         <= cnt_mode_e'(wr_data[0]);
                ctrl_o.clr_on_match <= wr_data[1];
            end
            if (wr_addr == A_PERIOD) period_o <= wr_data[HALF_W-1:0];
            if (wr_addr == A_EVCTL)  evmask_o <= wr_data[FLAG_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADDR = A_CMP0 + ADDR_W'(i);
        always_ff @(posedge clk) begin
            if (rst)                              cmp_o[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR) cmp_o[i] <= wr_data;
        end
    end
endmodule

// File: rtl/rtcc_counter.sv
module rtcc_counter
    import rtcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  ctrl_t             ctrl,
    input  logic [HALF_W-1:0] period,
    input  logic [CNT_W-1:0]  cmp0,
    output logic [CNT_W-1:0]  cnt_view,
    output logic [CNT_W-1:0]  nxt,
    output logic              wrap_ovf
);
    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] low;
    logic              top16, max32, hit0;

    assign low = cnt_q[HALF_W-1:0];

    always_comb begin
        top16 = (low == period) || (low == '1);
        max32 = (cnt_q == '1);
        hit0  = ctrl.clr_on_match && (cnt_q == cmp0);
        if (ctrl.mode == MODE_16) begin
            nxt      = top16 ? '0 : widen16(low + 1'b1);
            wrap_ovf = top16;
        end else begin
            nxt      = (max32 || hit0) ? '0 : cnt_q + 1'b1;
            wrap_ovf = max32;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= (ctrl.mode == MODE_32) ? load_val : widen16(load_val[HALF_W-1:0]);
        else if (adv)  cnt_q <= nxt;
    end

    assign cnt_view = (ctrl.mode == MODE_32) ? cnt_q : widen16(low);
endmodule

// File: rtl/rtcc_match.sv
module rtcc_match
    import rtcc_pkg::*;
(
    input  logic             adv,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] nxt,
    input  logic [CNT_W-1:0] cmp [NUM_CMP],
    output logic [NUM_CMP-1:0] hit
);
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
        logic active, eq;
        always_comb begin
            active = (i < active_channels(mode));
            eq     = (mode == MODE_32) ? (nxt == cmp[i])
                                       : (nxt[HALF_W-1:0] == cmp[i][HALF_W-1:0]);
            hit[i] = adv && active && eq;
        end
    end
endmodule

// File: rtl/rtc_compare_core.sv
module rtc_compare_core
    import rtcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       count_o,
    output logic [6:0]        flags_o,
    output logic [6:0]        evt_o
);
    ctrl_t              ctrl;
    logic [HALF_W-1:0]  period;
    logic [FLAG_W-1:0]  evmask;
    logic [CNT_W-1:0]   cmp [NUM_CMP];
    logic [CNT_W-1:0]   nxt;
    logic               wrap_ovf, load, adv, mode32;
    logic [NUM_CMP-1:0] hit;
    logic [FLAG_W-1:0]  set_v, clr_v, flags_q, evt_q;

    assign load   = wr_en && (wr_addr == A_COUNT);
    assign adv    = tick_en && !load;
    assign mode32 = (ctrl.mode == MODE_32);

    rtcc_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_o(ctrl), .period_o(period), .evmask_o(evmask), .cmp_o(cmp)
    );

    rtcc_counter u_cnt (
        .clk(clk), .rst(rst), .adv(adv), .load(load), .load_val(wr_data),
        .ctrl(ctrl), .period(period), .cmp0(cmp[0]),
        .cnt_view(count_o), .nxt(nxt), .wrap_ovf(wrap_ovf)
    );

    rtcc_match u_match (
        .adv(adv), .mode(ctrl.mode), .nxt(nxt), .cmp(cmp), .hit(hit)
    );

    assign set_v = {hit, adv && wrap_ovf};
    assign clr_v = (wr_en && wr_addr == A_FLAGS) ? wr_data[FLAG_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            evt_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_v) | set_v;
            evt_q   <= set_v & evmask;
        end
    end

    assign flags_o = flags_q;
    assign evt_o   = evt_q;
endmodule

// File: rtl/rtcc_chk.sv
module rtcc_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick_en,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [31:0] count_o,
    input logic [6:0]  flags_o,
    input logic [6:0]  evt_o,
    input logic        mode32
);
    // R2
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_en) |=> $stable(count_o));

    // R2
    step_count_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_en && mode32 && count_o != 32'hFFFF_FFFF && flags_o[1] == flags_o[1]
         && count_o + 32'd1 != 32'd0 && !$isunknown(count_o)) |=> (count_o == $past(count_o) + 32'd1) || (count_o == 32'd0));

    // R9
    load_count_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 4'd1 && mode32) |=> count_o == $past(wr_data));

    // R9
    load_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 4'd1) |=> evt_o == 7'd0);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == 4'd4) |=> (flags_o & $past(flags_o)) == $past(flags_o));

    // R8
    evt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_o & ~flags_o) == 7'd0);

    // R4
    half_view_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode32 && !(wr_en && wr_addr == 4'd0)) |=> count_o[31:16] == 16'd0);
endmodule

bind rtc_compare_core rtcc_chk u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_o(count_o), .flags_o(flags_o), .evt_o(evt_o),
    .mode32(mode32)
);

// File: tb/test_rtc_compare_core.sv
module test_rtc_compare_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] count_o;
    logic [6:0]  flags_o, evt_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rtc_compare_core i_rtc_compare_core (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .flags_o(flags_o), .evt_o(evt_o)
    );

    // {req, kind(1=tick), addr, data, exp count, exp flags, exp events}
    localparam int NV = 21;
    localparam logic [86:0] VEC [NV] = '{
        {4'd10, 1'b0, 4'd0, 32'h0,        32'h0,        7'h00, 7'h00}, // R10 16-bit mode
        {4'd10, 1'b0, 4'd2, 32'h3,        32'h0,        7'h00, 7'h00}, // R10 period 3
        {4'd10, 1'b0, 4'd9, 32'h2,        32'h0,        7'h00, 7'h00}, // R10 cmp1 = 2
        {4'd8,  1'b0, 4'd3, 32'h5,        32'h0,        7'h00, 7'h00}, // R8 mask ovf+cmp1
        {4'd2,  1'b1, 4'd0, 32'h0,        32'h1,        7'h00, 7'h00}, // R2
        {4'd6,  1'b1, 4'd0, 32'h0,        32'h2,        7'h04, 7'h04}, // R6 cmp1 hit
        {4'd2,  1'b1, 4'd0, 32'h0,        32'h3,        7'h04, 7'h00}, // R2
        {4'd4,  1'b1, 4'd0, 32'h0,        32'h0,        7'h7F, 7'h01}, // R4 period wrap, six channels
        {4'd7,  1'b0, 4'd4, 32'h7E,       32'h0,        7'h01, 7'h00}, // R7 w1c
        {4'd7,  1'b0, 4'd4, 32'h0,        32'h0,        7'h01, 7'h00}, // R7 zeros keep
        {4'd10, 1'b0, 4'd0, 32'h1,        32'h0,        7'h01, 7'h00}, // R10 32-bit mode
        {4'd9,  1'b0, 4'd1, 32'hFFFFFFFE, 32'hFFFFFFFE, 7'h01, 7'h00}, // R9 load
        {4'd7,  1'b0, 4'd4, 32'h1,        32'hFFFFFFFE, 7'h00, 7'h00}, // R7
        {4'd2,  1'b1, 4'd0, 32'h0,        32'hFFFFFFFF, 7'h00, 7'h00}, // R2
        {4'd3,  1'b1, 4'd0, 32'h0,        32'h0,        7'h1B, 7'h01}, // R3 full wrap, four channels
        {4'd7,  1'b0, 4'd4, 32'h7F,       32'h0,        7'h00, 7'h00}, // R7
        {4'd10, 1'b0, 4'd0, 32'h3,        32'h0,        7'h00, 7'h00}, // R10 clear-on-match
        {4'd10, 1'b0, 4'd8, 32'h2,        32'h0,        7'h00, 7'h00}, // R10 cmp0 = 2
        {4'd2,  1'b1, 4'd0, 32'h0,        32'h1,        7'h00, 7'h00}, // R2
        {4'd6,  1'b1, 4'd0, 32'h0,        32'h2,        7'h06, 7'h04}, // R6 cmp0 and cmp1
        {4'd5,  1'b1, 4'd0, 32'h0,        32'h0,        7'h1E, 7'h00}  // R5 no ovf, ch4/5 idle
    };

    task automatic check32(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic op(input logic tick, input logic wr, input logic [3:0] a, input logic [31:0] d);
        tick_en = tick; wr_en = wr; wr_addr = a; wr_data = d;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check32(1, "reset count", count_o, 32'h0);
        check32(1, "reset flags", {25'h0, flags_o}, 32'h0);
        check32(1, "reset events", {25'h0, evt_o}, 32'h0);
        // R1 default 32-bit: no wrap past 0xFFFF
        op(1'b0, 1'b1, 4'd1, 32'h0000FFFF);
        op(1'b1, 1'b0, 4'd0, 32'h0);
        check32(1, "default width count", count_o, 32'h00010000);
        check32(1, "default width flags", {25'h0, flags_o}, 32'h0);
        // R2 hold without tick
        op(1'b0, 1'b0, 4'd0, 32'h0);
        check32(2, "hold count", count_o, 32'h00010000);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            int req;
            req = int'(VEC[k][86:83]);
            op(VEC[k][82], !VEC[k][82], VEC[k][81:78], VEC[k][77:46]);
            check32(req, $sformatf("vec %0d count", k), count_o, VEC[k][45:14]);
            check32(req, $sformatf("vec %0d flags", k), {25'h0, flags_o}, {25'h0, VEC[k][13:7]});
            check32(req, $sformatf("vec %0d events", k), {25'h0, evt_o}, {25'h0, VEC[k][6:0]});
        end

        // R9 write beats tick; no flag even though cmp0 = 2 equals written value
        op(1'b1, 1'b1, 4'd1, 32'h2);
        check32(9, "load over tick count", count_o, 32'h2);
        check32(9, "load over tick flags", {25'h0, flags_o}, 32'h1E);
        check32(9, "load over tick events", {25'h0, evt_o}, 32'h0);

        // R4 16-bit view hides upper bits; wrap at 0xFFFF above period
        op(1'b0, 1'b1, 4'd4, 32'h7F);
        op(1'b0, 1'b1, 4'd0, 32'h0);
        op(1'b0, 1'b1, 4'd1, 32'h1234FFFF);
        check32(4, "16-bit load view", count_o, 32'h0000FFFF);
        op(1'b1, 1'b0, 4'd0, 32'h0);
        check32(4, "wrap at 0xFFFF count", count_o, 32'h0);
        check32(4, "wrap at 0xFFFF ovf", {31'h0, flags_o[0]}, 32'h1);

        // R8 masked event stays low while flag sets
        op(1'b0, 1'b1, 4'd3, 32'h0);
        op(1'b0, 1'b1, 4'd4, 32'h7F);
        op(1'b0, 1'b1, 4'd1, 32'h3);
        op(1'b1, 1'b0, 4'd0, 32'h0);
        check32(8, "masked event", {25'h0, evt_o}, 32'h0);
        check32(8, "masked flag ovf", {31'h0, flags_o[0]}, 32'h1);

        finish_run();
    end
endmodule